// File: doc/BRIEF.md
# Mixed-Latency Arithmetic Unit

This block is the arithmetic engine that sits behind a computation-unit manager. It receives a start request together with two operands and a small operation record (opcode, invert-first-operand, clear-first-operand, immediate-valid and an immediate value). It then returns one result through a valid/ready pair. The operation record shapes the operands before any arithmetic: the first operand can be forced to zero or bitwise inverted, and the immediate can stand in for the second operand.

Latency depends on the opcode. Add, multiply and logical shift-right are multi-cycle: the operands are captured when the start is accepted, and a down-counter runs for a fixed, parameterised number of clock edges before the result appears. Every other opcode is a subtraction with zero delay, whose result is presented in the same cycle that the start is accepted. Once a result is offered, it is held unchanged until the consumer takes it. No new start is accepted while an operation or an untaken result is outstanding.

Top module: `mixlat_alu`

## Requirements
- R1: After reset, `res_valid` is 0 and `start_ready` is 1.
- R2: Any opcode other than 0, 1 and 2 computes (first operand minus second operand) modulo 2^WIDTH. `res_valid` is 1 with that value in the same cycle as the accepted start, before any clock edge.
- R3: Opcode 0 (add) returns the sum modulo 2^WIDTH. `res_valid` rises exactly LATENCY rising clock edges after the edge that accepted the start.
- R4: Opcode 1 (multiply) returns the low WIDTH bits of the product, with the same latency as R3.
- R5: Opcode 2 (shift-right) returns the first operand shifted right logically by the value in the low log2(WIDTH) bits of the second operand, with the same latency as R3.
- R6: When `zero_a` is 1, the first operand is replaced by zero. This takes precedence over `inv_a`.
- R7: When `inv_a` is 1 and `zero_a` is 0, the first operand is bitwise inverted before the operation.
- R8: When `imm_valid` is 1, `imm_value` replaces `src_b` as the second operand.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` stays unchanged on the next cycle. A zero-delay result that is not taken in its own cycle is held in this way.
- R10: `start_ready` is 0 from the edge that accepts a multi-cycle start until the edge at which the result is taken. While `start_ready` is 0, a `start_valid` has no effect on the pending result.
- R11: Operands and operation controls are sampled only at the accepting edge. Later changes on those inputs do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Unit is idle and accepts a start |
| op_code | input | 3 | 0 add, 1 multiply, 2 shift-right, others subtract |
| inv_a | input | 1 | Invert the first operand |
| zero_a | input | 1 | Force the first operand to zero |
| imm_valid | input | 1 | Use the immediate as the second operand |
| imm_value | input | WIDTH | Immediate value |
| src_a | input | WIDTH | First operand |
| src_b | input | WIDTH | Second operand |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | WIDTH | Result value |

## Verification
A wrong control state shows up as a result that arrives one or more edges early or late. It can also show up as a `start_ready` that is high while a result is still pending, or as a held result that drops or changes before it is taken. All of these are visible at the ports within the LATENCY-edge window of the operation concerned. A wrong operand capture shows only in the final `res_data`, so each scenario changes every operand input right after acceptance. The arithmetic is compared against a reference that is computed differently: repeated halving for shifts and masked wide products for multiplication.

// File: rtl/mixlat_pkg.sv
`timescale 1ns/1ps
package mixlat_pkg;
  typedef logic [2:0] opcode_t;

  localparam opcode_t OPC_ADD = 3'd0;
  localparam opcode_t OPC_MUL = 3'd1;
  localparam opcode_t OPC_SHR = 3'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_t;

  function automatic logic op_is_multi(input opcode_t op);
    return (op == OPC_ADD) || (op == OPC_MUL) || (op == OPC_SHR);
  endfunction
endpackage

// File: rtl/mixlat_prep.sv
`timescale 1ns/1ps
// Operand shaping: clear / invert the first operand, immediate substitution.
module mixlat_prep #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] raw_a,
  input  logic [WIDTH-1:0] raw_b,
  input  logic             inv_a,
  input  logic             zero_a,
  input  logic             imm_valid,
  input  logic [WIDTH-1:0] imm_value,
  output logic [WIDTH-1:0] opa,
  output logic [WIDTH-1:0] opb
);
  always_comb begin
    if (zero_a)      opa = '0;
    else if (inv_a)  opa = ~raw_a;
    else             opa = raw_a;
    opb = imm_valid ? imm_value : raw_b;
  end
endmodule

// File: rtl/mixlat_exec.sv
`timescale 1ns/1ps
// Pure arithmetic; every opcode result is computed by its own function.
module mixlat_exec
  import mixlat_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  opcode_t          op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res
);
  localparam int SHW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  function automatic logic [WIDTH-1:0] f_add(input logic [WIDTH-1:0] x, y);
    return x + y;
  endfunction

  function automatic logic [WIDTH-1:0] f_sub(input logic [WIDTH-1:0] x, y);
    return x - y;
  endfunction

  function automatic logic [WIDTH-1:0] f_mul(input logic [WIDTH-1:0] x, y);
    logic [2*WIDTH-1:0] wide;
    wide = {{WIDTH{1'b0}}, x} * {{WIDTH{1'b0}}, y};
    return wide[WIDTH-1:0];
  endfunction

  function automatic logic [WIDTH-1:0] f_shr(input logic [WIDTH-1:0] x,
                                             input logic [SHW-1:0] amt);
    return x >> amt;
  endfunction

  logic [SHW-1:0] shamt;
  logic [WIDTH-1:0] shr_res;

  generate
    if (WIDTH > 1) begin : g_shamt
      assign shamt = opb[SHW-1:0];
    end else begin : g_shamt1
      assign shamt = 1'b0;
    end
  endgenerate

  assign shr_res = f_shr(opa, shamt);

  always_comb begin
    unique case (op)
      OPC_ADD: res = f_add(opa, opb);
      OPC_MUL: res = f_mul(opa, opb);
      OPC_SHR: res = shr_res;
      default: res = f_sub(opa, opb);
    endcase
  end
endmodule

// File: rtl/mixlat_ctrl.sv
`timescale 1ns/1ps
// Sequencer: acceptance, operand capture, latency down-counter, result hold.
module mixlat_ctrl
  import mixlat_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  opcode_t          op_in,
  input  logic [WIDTH-1:0] opa_in,
  input  logic [WIDTH-1:0] opb_in,
  input  logic             res_ready,
  input  logic [WIDTH-1:0] exec_res,
  output logic             start_ready,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_data,
  output logic             use_held,
  output opcode_t          held_op,
  output logic [WIDTH-1:0] held_a,
  output logic [WIDTH-1:0] held_b,
  output logic             accept_evt,
  output logic             finish_evt
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(LATENCY - 1);

  seq_state_t     st;
  logic [CW-1:0]  cnt;
  logic [WIDTH-1:0] res_q;
  logic           multi;
  logic           comb_fire;

  assign start_ready = (st == ST_IDLE);
  assign accept_evt  = start_valid && start_ready;
  assign multi       = op_is_multi(op_in);
  assign comb_fire   = accept_evt && !multi;
  assign finish_evt  = (st == ST_RUN) && (cnt == '0);
  assign use_held    = (st == ST_RUN);

  always_comb begin
    res_valid = (st == ST_HOLD) || comb_fire;
    if (st == ST_HOLD)  res_data = res_q;
    else if (comb_fire) res_data = exec_res;
    else                res_data = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      res_q   <= '0;
      held_op <= OPC_ADD;
      held_a  <= '0;
      held_b  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept_evt) begin
            if (multi) begin
              st      <= ST_RUN;
              cnt     <= CNT_LOAD;
              held_op <= op_in;
              held_a  <= opa_in;
              held_b  <= opb_in;
            end else if (!res_ready) begin
              st    <= ST_HOLD;
              res_q <= exec_res;
            end
          end
        end
        ST_RUN: begin
          if (finish_evt) begin
            st    <= ST_HOLD;
            res_q <= exec_res;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (res_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mixlat_alu.sv
`timescale 1ns/1ps
module mixlat_alu
  import mixlat_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [2:0]       op_code,
  input  logic             inv_a,
  input  logic             zero_a,
  input  logic             imm_valid,
  input  logic [WIDTH-1:0] imm_value,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_data
);
  logic [WIDTH-1:0] live_a, live_b;
  logic [WIDTH-1:0] held_a, held_b;
  logic [WIDTH-1:0] ex_a, ex_b, ex_res;
  opcode_t          held_op, ex_op;
  logic             use_held;
  logic             accept_evt;
  logic             finish_evt;

  mixlat_prep #(.WIDTH(WIDTH)) u_prep (
    .raw_a(src_a), .raw_b(src_b), .inv_a(inv_a), .zero_a(zero_a),
    .imm_valid(imm_valid), .imm_value(imm_value),
    .opa(live_a), .opb(live_b)
  );

  assign ex_op = use_held ? held_op : op_code;
  assign ex_a  = use_held ? held_a  : live_a;
  assign ex_b  = use_held ? held_b  : live_b;

  mixlat_exec #(.WIDTH(WIDTH)) u_exec (
    .op(ex_op), .opa(ex_a), .opb(ex_b), .res(ex_res)
  );

  mixlat_ctrl #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .op_in(op_code), .opa_in(live_a), .opb_in(live_b),
    .res_ready(res_ready), .exec_res(ex_res),
    .start_ready(start_ready), .res_valid(res_valid), .res_data(res_data),
    .use_held(use_held), .held_op(held_op), .held_a(held_a), .held_b(held_b),
    .accept_evt(accept_evt), .finish_evt(finish_evt)
  );
endmodule

// File: rtl/mixlat_alu_chk.sv
`timescale 1ns/1ps
module mixlat_alu_chk
  import mixlat_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_valid,
  input logic             start_ready,
  input logic [2:0]       op_code,
  input logic             inv_a,
  input logic             zero_a,
  input logic             imm_valid,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic             res_valid,
  input logic             res_ready,
  input logic [WIDTH-1:0] res_data,
  input logic             accept_evt,
  input logic             finish_evt
);
  localparam int LW = $clog2(LATENCY + 2) + 1;

  logic          pend;
  logic [LW-1:0] lat_cnt;
  logic          multi_acc;
  logic          comb_acc;

  assign multi_acc = start_valid && start_ready && op_is_multi(op_code);
  assign comb_acc  = accept_evt && !op_is_multi(op_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      lat_cnt <= '0;
    end else if (multi_acc) begin
      pend    <= 1'b1;
      lat_cnt <= '0;
    end else if (pend && res_valid) begin
      pend    <= 1'b0;
    end else if (pend) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  // R3: multi-cycle result appears exactly LATENCY edges after acceptance
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    pend && res_valid |-> lat_cnt == LW'(LATENCY));

  a_r3_finish_shows: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> res_valid);

  // R2: zero-delay subtraction visible in the accepting cycle
  a_r2_comb_now: assert property (@(posedge clk) disable iff (!rst_n)
    comb_acc && !inv_a && !zero_a && !imm_valid |->
      res_valid && res_data == WIDTH'(src_a - src_b));

  // R6: cleared first operand wins over inversion
  a_r6_zero_wins: assert property (@(posedge clk) disable iff (!rst_n)
    comb_acc && zero_a && !imm_valid |-> res_data == WIDTH'('0 - src_b));

  // R9: an untaken result is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && res_data == $past(res_data));

  // R10: no new start while busy
  a_r10_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    multi_acc |=> !start_ready);

  a_r10_pending_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> !start_ready);
endmodule

bind mixlat_alu mixlat_alu_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
  .start_ready(start_ready), .op_code(op_code), .inv_a(inv_a),
  .zero_a(zero_a), .imm_valid(imm_valid), .src_a(src_a), .src_b(src_b),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .accept_evt(accept_evt), .finish_evt(finish_evt)
);

// File: tb/tb_mixlat_alu.sv
`timescale 1ns/1ps
module tb_mixlat_alu;
  localparam int W   = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic start_valid, start_ready;
  logic [2:0] op_code;
  logic inv_a, zero_a, imm_valid;
  logic [W-1:0] imm_value, src_a, src_b, res_data;
  logic res_valid, res_ready;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mixlat_alu #(.WIDTH(W), .LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .start_ready(start_ready), .op_code(op_code), .inv_a(inv_a),
    .zero_a(zero_a), .imm_valid(imm_valid), .imm_value(imm_value),
    .src_a(src_a), .src_b(src_b), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model, written independently of the design's structure.
  function automatic longint ref_res(input int code, input longint a, input longint b,
                                     input bit inv, input bit zer, input bit iv,
                                     input longint imm);
    longint mask = (64'd1 << W) - 1;
    longint x = zer ? 0 : (inv ? (a ^ mask) : a);
    longint y = iv ? imm : b;
    longint r;
    case (code)
      0: r = (x + y) & mask;
      1: r = (x * y) & mask;
      2: begin
        r = x;
        for (int k = 0; k < (y % W); k++) r = r / 2;
      end
      default: r = (x + (mask + 1) - y) & mask;
    endcase
    return r;
  endfunction

  task automatic run_op(input string req, input int code, input longint a,
                        input longint b, input bit inv, input bit zer,
                        input bit iv, input longint imm, input bit fast);
    longint exp = ref_res(code, a, b, inv, zer, iv, imm);
    bit multi = (code <= 2);
    int n;
    @(negedge clk);
    op_code = code[2:0]; src_a = W'(a); src_b = W'(b);
    inv_a = inv; zero_a = zer; imm_valid = iv; imm_value = W'(imm);
    start_valid = 1'b1; res_ready = fast;
    #1;
    chk({req, " R10 ready when idle"}, start_ready, 1);
    if (!multi) begin
      chk({req, " R2 same-cycle valid"}, res_valid, 1);
      chk({req, " R2 same-cycle data"}, res_data, exp);
    end
    @(negedge clk);
    // R11: disturb every input after acceptance
    start_valid = 1'b0; src_a = ~src_a; src_b = src_b + 16'd5;
    imm_value = ~imm_value; inv_a = ~inv_a; zero_a = ~zero_a;
    imm_valid = ~imm_valid; op_code = 3'd5;
    if (!multi && fast) begin
      #1;
      chk({req, " R2 taken in own cycle"}, res_valid, 0);
      chk({req, " R2 idle again"}, start_ready, 1);
      return;
    end
    if (multi) begin
      // R10: a start offered while busy is refused
      start_valid = 1'b1; op_code = 3'd0;
      #1;
      chk({req, " R10 busy refuses start"}, start_ready, 0);
      n = 0;
      while (!res_valid && n < 50) begin
        @(negedge clk);
        n++;
      end
      start_valid = 1'b0;
      chk({req, " R3 latency"}, n, LAT);
    end
    #1;
    chk({req, " result valid"}, res_valid, 1);
    chk({req, " result R11"}, res_data, exp);
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      start_valid = (h == 0);
      #1;
      chk({req, " R9 held valid"}, res_valid, 1);
      chk({req, " R9 held data"}, res_data, exp);
      chk({req, " R10 refuse while pending"}, start_ready, 0);
    end
    start_valid = 1'b0;
    @(negedge clk);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    #1;
    chk({req, " R9 released after take"}, res_valid, 0);
    chk({req, " R10 ready after take"}, start_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_valid = 1'b0; res_ready = 1'b0; op_code = '0;
    inv_a = 0; zero_a = 0; imm_valid = 0; imm_value = '0;
    src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset valid", res_valid, 0);
    chk("R1 reset ready", start_ready, 1);

    run_op("R6 R8 zero-a add imm", 0, 5, 2, 0, 1, 1, 8, 0);      // 8
    run_op("R8 add imm", 0, 5, 2, 0, 0, 1, 8, 0);                // 13
    run_op("R3 add", 0, 5, 2, 0, 0, 0, 0, 0);                    // 7
    run_op("R7 inv add", 0, 5, 2, 1, 0, 0, 0, 0);                // 65532
    run_op("R6 zero add", 0, 5, 2, 0, 1, 0, 0, 0);               // 2
    run_op("R6 zero beats inv", 0, 9, 4, 1, 1, 0, 0, 0);         // 4
    run_op("R3 add wrap", 0, 16'hFFFF, 2, 0, 0, 0, 0, 0);        // 1
    run_op("R4 mul", 1, 300, 300, 0, 0, 0, 0, 0);                // 24464
    run_op("R5 shr", 2, 16'h8000, 16'h0013, 0, 0, 0, 0, 0);      // 0x1000
    run_op("R2 sub held", 3, 5, 2, 0, 0, 0, 0, 0);               // 3
    run_op("R2 sub wrap taken", 7, 2, 5, 0, 0, 0, 0, 1);         // 65533
    run_op("R2 R6 sub zero", 4, 7, 3, 1, 1, 0, 0, 1);            // 65533
    run_op("R2 R8 sub imm", 6, 20, 1, 0, 0, 1, 6, 0);            // 14

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule